// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Unit

This unit keeps one interrupt-enable word and one interrupt-status word for each locality. It also exposes a read-only vector word and drives one interrupt line that all localities share. Four kinds of event pulse can arrive: data available, status valid, locality changed and command ready. Each pulse carries the number of the locality it targets. A pulse is recorded in that locality's status word only when the locality has enabled interrupts globally and has also enabled that source. Recording a pulse raises the shared line.

Software reaches the registers over a simple request bus. The upper address bits select the locality and the lower bits select the register. Accesses may be 1, 2 or 4 bytes wide and are placed on byte lanes by the low two address bits. Locality arbitration happens elsewhere, and the number of the currently active locality arrives as an input. Only that locality may change its enable or status word. A write-one to the status word clears bits, and the line falls when such a clear empties the written locality's status.

Two small state machines control the unit. The access sequencer has two states. `ACC_IDLE` means no read data is presented. Any read request moves it to `ACC_RDATA`, where the read word is held for one cycle. It stays in `ACC_RDATA` while reads continue and returns to `ACC_IDLE` otherwise. The line controller moves from `LINE_QUIET` to `LINE_RAISED` when any event is latched. It moves from `LINE_RAISED` back to `LINE_QUIET` when a status clear leaves the written locality at zero and no event is latched in the same cycle.

Top module: `loc_irq_unit`

## Requirements
- R1: After reset, every enable word reads 0x0000_0008 (polarity code 01, all enables off), every status word reads 0, the line is inactive, and `bus_rvalid` is low.
- R2: Only enable bits 31 (global), 7 (command ready), 4:3 (polarity), 2 (locality changed), 1 (status valid) and 0 (data available) store written values (mask 0x8000_009F). All other bits read 0.
- R3: `evt_src` bit 0 maps to status bit 0, bit 1 to bit 1, bit 2 to bit 2 and bit 3 to bit 7. An event sets a status bit and raises the line only when the target locality has both enable bit 31 and that source's enable bit set.
- R4: Writing ones to a status word clears those bits. If the clear leaves that locality's status at zero, the line falls one edge later. If bits remain set, the line stays high.
- R5: Writes to an enable or status word from a locality that is not the active one have no effect. No locality is active when `active_loc` >= NUM_LOC.
- R6: The vector word at offset 0x0C returns bits [3:0] of the configured line number, and writes to it are ignored.
- R7: Write data is right-aligned on the bus and is shifted left by 8×addr[1:0]. Bytes outside the access keep their value. Read data is shifted right by 8×addr[1:0] and masked to the access size (`bus_size` 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes).
- R8: An event whose `evt_loc` is NUM_LOC or higher changes no status and does not raise the line.
- R9: `irq_pin` is the inverse of `irq_line` when the active locality's polarity field (enable bits 4:3) equals 01, and equals `irq_line` otherwise. When no locality is active, the code 01 applies.
- R10: When an event is latched in the same cycle as a clear that empties a status word, the line is high after the edge.
- R11: The line falls on a status clear that empties the written locality even if another locality still holds status bits.
- R12: The locality is addr[14:12] and the register offset is addr[11:0]. The enable word is at 0x08, the vector at 0x0C and the status at 0x10. Other offsets, and localities of NUM_LOC or higher, read as all ones. Read data appears with `bus_rvalid` high in the cycle after the request edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, sampled on the rising edge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: locality in [14:12], offset in [11:0] |
| bus_size | input | 2 | Access width code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| bus_wdata | input | 32 | Right-aligned write data |
| bus_rdata | output | 32 | Right-aligned read data |
| bus_rvalid | output | 1 | Read data valid |
| active_loc | input | LOC_W | Currently active locality; NUM_LOC or more means none |
| evt_valid | input | 1 | Event pulse |
| evt_src | input | 4 | Event sources: data available, status valid, locality changed, command ready |
| evt_loc | input | LOC_W | Target locality of the event |
| irq_line | output | 1 | Logical interrupt request, active high |
| irq_pin | output | 1 | Physical line with the selected polarity applied |

## Verification
The hardest situation to reach is a clear that empties one locality's status in the same cycle that another locality latches a new event. It requires two enabled localities, a raised line, and a bus write aligned with an event pulse. The bench reaches it by first arming a second locality through its own active period. It then switches the active locality back and issues the write and the event from one task, within the same clock period. A related situation is the shared line falling while a different locality still holds status. The bench sets this up by latching into two localities before clearing only one of them.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

    localparam int DATA_W = 32;
    localparam int GLOBAL_BIT = 31;

    localparam logic [31:0] EN_WMASK = 32'h8000_009F;
    localparam logic [31:0] SRC_MASK = 32'h0000_0087;
    localparam logic [31:0] EN_RESET = 32'h0000_0008;
    localparam logic [1:0]  POL_ACTIVE_LOW = 2'b01;

    localparam logic [11:0] OFF_ENABLE = 12'h008;
    localparam logic [11:0] OFF_VECTOR = 12'h00C;
    localparam logic [11:0] OFF_STATUS = 12'h010;

    typedef enum logic {
        ACC_IDLE  = 1'b0,
        ACC_RDATA = 1'b1
    } acc_state_e;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

    function automatic logic [31:0] src_to_bits(input logic [3:0] src);
        logic [31:0] r;
        r    = '0;
        r[0] = src[0];
        r[1] = src[1];
        r[2] = src[2];
        r[7] = src[3];
        return r;
    endfunction

endpackage

// File: rtl/lirq_lane_align.sv
module lirq_lane_align (
    input  logic [1:0]  lane,
    input  logic [1:0]  size,
    input  logic [31:0] wdata,
    input  logic [31:0] rword,
    output logic [31:0] wbits,
    output logic [31:0] bmask,
    output logic [31:0] rdata
);
    logic [3:0]  span;
    logic [3:0]  lanes;
    logic [31:0] span_bits;

    always_comb begin
        unique case (size)
            2'd0:    span = 4'b0001;
            2'd1:    span = 4'b0011;
            default: span = 4'b1111;
        endcase
        lanes = span << lane;
        for (int b = 0; b < 4; b++) begin
            bmask[8*b +: 8]     = {8{lanes[b]}};
            span_bits[8*b +: 8] = {8{span[b]}};
        end
        wbits = wdata << {lane, 3'b000};
        rdata = (rword >> {lane, 3'b000}) & span_bits;
    end
endmodule

// File: rtl/lirq_loc_regs.sv
module lirq_loc_regs
    import lirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_st,
    input  logic [31:0] wbits,
    input  logic [31:0] bmask,
    input  logic        evt_hit,
    input  logic [31:0] evt_bits,
    output logic [31:0] en_q,
    output logic [31:0] st_q,
    output logic        latch,
    output logic        clr_zero
);
    logic [31:0] hit_bits;
    logic [31:0] clr_bits;

    assign hit_bits = (evt_hit && en_q[GLOBAL_BIT]) ? (evt_bits & en_q & SRC_MASK) : '0;
    assign latch    = |hit_bits;
    assign clr_bits = wr_st ? (wbits & bmask & SRC_MASK) : '0;
    assign clr_zero = (|clr_bits) && (|st_q) && ((st_q & ~clr_bits) == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= EN_RESET;
            st_q <= '0;
        end else begin
            if (wr_en) begin
                en_q <= (en_q & ~(bmask & EN_WMASK)) | (wbits & bmask & EN_WMASK);
            end
            st_q <= (st_q & ~clr_bits) | hit_bits;
        end
    end

    AST_STATUS_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q & ~$past(st_q)) != '0) |-> ($past(evt_hit) && $past(en_q[GLOBAL_BIT]))); // R3

endmodule

// File: rtl/lirq_line_fsm.sv
module lirq_line_fsm
    import lirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_latch,
    input  logic drop_req,
    input  logic active_low,
    output logic line,
    output logic pin
);
    line_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (any_latch) state_d = LINE_RAISED;
            LINE_RAISED: if (drop_req && !any_latch) state_d = LINE_QUIET;
            default:     state_d = LINE_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            LINE_RAISED: line = 1'b1;
            default:     line = 1'b0;
        endcase
        pin = active_low ? ~line : line;
    end

    AST_LINE_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line) |-> $past(any_latch)); // R3
    AST_LINE_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line) |-> ($past(drop_req) && !$past(any_latch))); // R4

endmodule

// File: rtl/loc_irq_unit.sv
module loc_irq_unit
    import lirq_pkg::*;
#(
    parameter int NUM_LOC    = 5,
    parameter int LOC_W      = 3,
    parameter int LOC_SHIFT  = 12,
    parameter int ADDR_W     = 16,
    parameter int IRQ_VECTOR = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [LOC_W-1:0]  active_loc,
    input  logic              evt_valid,
    input  logic [3:0]        evt_src,
    input  logic [LOC_W-1:0]  evt_loc,
    output logic              irq_line,
    output logic              irq_pin
);
    localparam int OFF_W = LOC_SHIFT;
    localparam logic [3:0] VEC_NIBBLE = IRQ_VECTOR[3:0];

    logic [LOC_W-1:0] acc_loc;
    logic [OFF_W-1:0] word_off;
    logic             acc_ok;
    logic [31:0]      wbits, bmask, rword, rdata_al;
    logic [31:0]      evt_bits;
    logic [31:0]      en_a [NUM_LOC];
    logic [31:0]      st_a [NUM_LOC];
    logic [NUM_LOC-1:0] latch_v, clr_v;
    logic [31:0]      sel_en, sel_st;
    logic [1:0]       act_pol;
    acc_state_e       acc_q, acc_d;
    logic [31:0]      rdata_q;

    assign acc_loc  = bus_addr[LOC_SHIFT +: LOC_W];
    assign word_off = {bus_addr[OFF_W-1:2], 2'b00};
    assign acc_ok   = int'(acc_loc) < NUM_LOC;
    assign evt_bits = src_to_bits(evt_src);

    lirq_lane_align u_align (
        .lane  (bus_addr[1:0]),
        .size  (bus_size),
        .wdata (bus_wdata),
        .rword (rword),
        .wbits (wbits),
        .bmask (bmask),
        .rdata (rdata_al)
    );

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
        logic is_acc, is_act, wr_en_g, wr_st_g, hit_g;
        assign is_acc  = acc_loc == LOC_W'(g);
        assign is_act  = active_loc == LOC_W'(g);
        assign wr_en_g = bus_req && bus_we && is_acc && is_act && (word_off == OFF_W'(OFF_ENABLE));
        assign wr_st_g = bus_req && bus_we && is_acc && is_act && (word_off == OFF_W'(OFF_STATUS));
        assign hit_g   = evt_valid && (evt_loc == LOC_W'(g));

        lirq_loc_regs u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en_g),
            .wr_st    (wr_st_g),
            .wbits    (wbits),
            .bmask    (bmask),
            .evt_hit  (hit_g),
            .evt_bits (evt_bits),
            .en_q     (en_a[g]),
            .st_q     (st_a[g]),
            .latch    (latch_v[g]),
            .clr_zero (clr_v[g])
        );

        AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            $past(bus_req && bus_we && is_acc && !is_act && !evt_valid)
            |-> ($stable(en_a[g]) && $stable(st_a[g]))); // R5
        AST_BAD_EVENT_DISCARDED: assert property (@(posedge clk) disable iff (!rst_n)
            $past(evt_valid && (int'(evt_loc) >= NUM_LOC) && !bus_req)
            |-> $stable(st_a[g])); // R8
    end

    always_comb begin
        sel_en  = '0;
        sel_st  = '0;
        act_pol = POL_ACTIVE_LOW;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (acc_loc == LOC_W'(i)) begin
                sel_en = en_a[i];
                sel_st = st_a[i];
            end
            if (active_loc == LOC_W'(i)) begin
                act_pol = en_a[i][4:3];
            end
        end
    end

    always_comb begin
        rword = '1;
        if (acc_ok) begin
            if (word_off == OFF_W'(OFF_ENABLE))      rword = sel_en;
            else if (word_off == OFF_W'(OFF_STATUS)) rword = sel_st;
            else if (word_off == OFF_W'(OFF_VECTOR)) rword = {28'h0, VEC_NIBBLE};
        end
    end

    lirq_line_fsm u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_latch  (|latch_v),
        .drop_req   (|clr_v),
        .active_low (act_pol == POL_ACTIVE_LOW),
        .line       (irq_line),
        .pin        (irq_pin)
    );

    always_comb begin
        acc_d = ACC_IDLE;
        unique case (acc_q)
            ACC_IDLE:  if (bus_req && !bus_we) acc_d = ACC_RDATA;
            ACC_RDATA: if (bus_req && !bus_we) acc_d = ACC_RDATA;
            default:   acc_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= ACC_IDLE;
            rdata_q <= '0;
        end else begin
            acc_q <= acc_d;
            if (bus_req && !bus_we) rdata_q <= rdata_al;
        end
    end

    always_comb begin
        unique case (acc_q)
            ACC_RDATA: bus_rvalid = 1'b1;
            default:   bus_rvalid = 1'b0;
        endcase
        bus_rdata = rdata_q;
    end

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_req && !bus_we)); // R12

endmodule

// File: tb/loc_irq_unit_bench.sv
module loc_irq_unit_bench;
    localparam int NL = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [2:0]  active_loc = 3'd7;
    logic        evt_valid = 1'b0;
    logic [3:0]  evt_src = '0;
    logic [2:0]  evt_loc = '0;
    logic        irq_line, irq_pin;

    int checks = 0;
    int fails = 0;

    typedef struct {
        logic [31:0] v;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    loc_irq_unit #(.NUM_LOC(NL), .IRQ_VECTOR(27)) u_loc_irq_unit (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .active_loc(active_loc),
        .evt_valid(evt_valid), .evt_src(evt_src), .evt_loc(evt_loc),
        .irq_line(irq_line), .irq_pin(irq_pin)
    );

    function automatic logic [15:0] mk(input int loc, input int off);
        return 16'((loc << 12) | off);
    endfunction

    task automatic wr(input int loc, input int off, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = mk(loc, off); bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int loc, input int off, input logic [1:0] sz,
                      input logic [31:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = mk(loc, off); bus_size = sz;
        it.v = e; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic ev(input int loc, input logic [3:0] src);
        @(negedge clk);
        evt_valid = 1'b1; evt_loc = 3'(loc); evt_src = src;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic wr_ev(input int loc, input int off, input logic [31:0] d,
                         input int eloc, input logic [3:0] esrc);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = mk(loc, off); bus_size = 2'd2; bus_wdata = d;
        evt_valid = 1'b1; evt_loc = 3'(eloc); evt_src = esrc;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; evt_valid = 1'b0;
    endtask

    task automatic chk_irq(input logic el, input logic ep, input string tag);
        checks++;
        if (irq_line !== el || irq_pin !== ep) begin
            fails++;
            $display("FAIL %s: line/pin actual %b/%b expected %b/%b", tag, irq_line, irq_pin, el, ep);
        end
    endtask

    // monitor: pops the expected read data as results appear
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R12: unexpected read data actual %h expected none", bus_rdata);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                if (bus_rdata !== it.v) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.v);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R9 default polarity active-low
        chk_irq(1'b0, 1'b1, "R1 R9 reset");
        checks++;
        if (bus_rvalid !== 1'b0) begin
            fails++;
            $display("FAIL R1: rvalid actual %b expected 0", bus_rvalid);
        end
        rd(0, 'h08, 2'd2, 32'h0000_0008, "R1 enable reset");
        rd(0, 'h10, 2'd2, 32'h0, "R1 status reset");
        rd(3, 'h08, 2'd2, 32'h0000_0008, "R1 enable reset loc3");
        // R5 no active locality
        wr(0, 'h08, 2'd2, 32'hFFFF_FFFF);
        rd(0, 'h08, 2'd2, 32'h0000_0008, "R5 write with none active");
        // R2 writable mask
        active_loc = 3'd0;
        wr(0, 'h08, 2'd2, 32'hFFFF_FFFF);
        rd(0, 'h08, 2'd2, 32'h8000_009F, "R2 writable mask");
        chk_irq(1'b0, 1'b0, "R9 active-high polarity idle");
        // R6 vector
        rd(0, 'h0C, 2'd2, 32'h0000_000B, "R6 vector");
        wr(0, 'h0C, 2'd2, 32'h0000_0005);
        rd(0, 'h0C, 2'd2, 32'h0000_000B, "R6 vector write ignored");
        // R12 map
        rd(0, 'h20, 2'd2, 32'hFFFF_FFFF, "R12 unmapped offset");
        rd(6, 'h08, 2'd2, 32'hFFFF_FFFF, "R12 absent locality");
        // R7 sub-word
        wr(0, 'h08, 2'd0, 32'h0000_0000);
        rd(0, 'h08, 2'd2, 32'h8000_0000, "R7 byte0 write");
        wr(0, 'h0B, 2'd0, 32'h0000_0000);
        wr(0, 'h08, 2'd1, 32'hFFFF_0081);
        rd(0, 'h08, 2'd2, 32'h0000_0081, "R7 halfword write");
        wr(0, 'h0B, 2'd0, 32'h0000_0080);
        rd(0, 'h08, 2'd2, 32'h8000_0081, "R7 byte3 write");
        rd(0, 'h0B, 2'd0, 32'h0000_0080, "R7 byte3 read");
        rd(0, 'h0A, 2'd1, 32'h0000_8000, "R7 upper half read");
        // R3 gating by source enable
        ev(0, 4'b0010);
        chk_irq(1'b0, 1'b0, "R3 disabled source");
        rd(0, 'h10, 2'd2, 32'h0, "R3 disabled source status");
        ev(0, 4'b0001);
        chk_irq(1'b1, 1'b1, "R3 R9 enabled source");
        ev(0, 4'b1000);
        rd(0, 'h10, 2'd2, 32'h0000_0081, "R3 command-ready maps to bit7");
        // R4 write-one-to-clear
        wr(0, 'h10, 2'd2, 32'h0000_0001);
        chk_irq(1'b1, 1'b1, "R4 partial clear keeps line");
        rd(0, 'h10, 2'd2, 32'h0000_0080, "R4 partial clear");
        wr(0, 'h10, 2'd2, 32'h0000_0080);
        chk_irq(1'b0, 1'b0, "R4 clear to zero drops line");
        // R3 global enable off
        wr(0, 'h08, 2'd2, 32'h0000_0081);
        ev(0, 4'b0001);
        chk_irq(1'b0, 1'b0, "R3 global enable off");
        rd(0, 'h10, 2'd2, 32'h0, "R3 global enable off status");
        wr(0, 'h08, 2'd2, 32'h8000_0081);
        // R8 absent localities
        ev(5, 4'b1111);
        ev(7, 4'b1111);
        chk_irq(1'b0, 1'b0, "R8 absent locality event");
        // R9 active-low on loc2, R5 foreign clear
        active_loc = 3'd2;
        wr(2, 'h08, 2'd2, 32'h8000_008F);
        ev(2, 4'b0100);
        chk_irq(1'b1, 1'b0, "R9 active-low raised");
        active_loc = 3'd0;
        @(negedge clk);
        chk_irq(1'b1, 1'b1, "R9 polarity follows active locality");
        wr(2, 'h10, 2'd2, 32'h0000_0004);
        chk_irq(1'b1, 1'b1, "R5 foreign clear ignored line");
        rd(2, 'h10, 2'd2, 32'h0000_0004, "R5 foreign clear ignored status");
        // R11 shared line drops with other status pending
        ev(0, 4'b0001);
        active_loc = 3'd2;
        wr(2, 'h10, 2'd2, 32'h0000_0004);
        chk_irq(1'b0, 1'b1, "R11 drop with loc0 pending");
        rd(0, 'h10, 2'd2, 32'h0000_0001, "R11 loc0 status kept");
        // R10 event beats clear in same cycle
        active_loc = 3'd0;
        ev(0, 4'b1000);
        chk_irq(1'b1, 1'b1, "R10 setup");
        wr_ev(0, 'h10, 32'h0000_0081, 2, 4'b0001);
        chk_irq(1'b1, 1'b1, "R10 event wins over clear");
        rd(0, 'h10, 2'd2, 32'h0, "R10 loc0 cleared");
        rd(2, 'h10, 2'd2, 32'h0000_0001, "R10 loc2 latched");
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R12: pending reads actual %0d expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule